// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Flag

This block is a purely combinational shifter for an n-bit register operand that also maintains the processor's carry flag. Each evaluation takes an operand, an unsigned shift count, the present carry and a 4-bit operation code. It returns the shifted or rotated operand, the new carry and an overflow indication. The overflow is meaningful only for arithmetic left shifts.

The carry always ends up holding the last bit that left the operand. For the two through-carry rotations, the carry takes part in the rotation itself as an extra bit, so the ring is n+1 bits wide. Three further codes clear, set or invert the carry and pass the operand through unchanged. A datapath instantiates the block between the register read and the register write-back. It sends the carry output to the flag register.

Top module: `shrot_unit`

## Requirements
- R1: With a count of zero, every shift and rotate code (0 to 7) returns the operand unchanged, returns carry_o equal to carry_i, and drives ovf_o low.
- R2: Code 0 (logical left) shifts toward the most significant end and fills zeros at the low end. carry_o is the last bit shifted out of bit n-1.
- R3: Code 1 (logical right) shifts toward bit 0 and fills zeros at the high end. carry_o is the last bit shifted out of bit 0.
- R4: Code 2 (arithmetic right) fills the vacated high positions with the original bit n-1. carry_o is the last bit shifted out of bit 0.
- R5: Code 3 (arithmetic left) gives the same result and carry as code 0. ovf_o is high when bit n-1 changed value at any single step of the shift.
- R6: Code 4 (rotate left) and code 5 (rotate right) move the bits that leave one end into the other end. carry_o is a copy of the last bit that crossed over.
- R7: Code 6 (rotate left through carry) and code 7 (rotate right through carry) treat {carry, operand} as an (n+1)-bit ring. At each step the old carry enters the vacated end bit, and the bit leaving the far end becomes the new carry.
- R8: Logical shifts by n or more positions return all zeros. Arithmetic right by n or more returns n copies of the sign bit. The carry follows the step rule: a logical shift by more than n gives carry 0, and an arithmetic right shift by n or more gives the sign bit.
- R9: Codes 4 and 5 use the count modulo n. Codes 6 and 7 use the count modulo n+1.
- R10: Code 8 clears the carry, code 9 sets it and code 10 inverts it. Codes 11 to 15 leave the carry as it is. All of codes 8 to 15 return the operand unchanged, whatever the count.
- R11: ovf_o is low for every code other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | WIDTH | Operand to shift or rotate |
| count_i | input | CNT_W | Unsigned shift or rotate count |
| carry_i | input | 1 | Present carry flag |
| op_i | input | 4 | Operation code (see R2 to R10) |
| result_o | output | WIDTH | Shifted or rotated operand |
| carry_o | output | 1 | Updated carry flag |
| ovf_o | output | 1 | Sign-change flag of an arithmetic left shift |

## Verification
Two things always appear in the same evaluation: the operand result and the carry update. For arithmetic left shifts, the overflow flag appears in that evaluation as well. All of them are produced from one count. The hard cases are where these interact: a count equal to the width, a count just past it, a count that is a multiple of the ring length, and a nonzero count that reduces to a zero rotation. For each of these, the bench drives one vector per clock and compares all three outputs together against a model. The model performs the operation one bit step at a time, as many steps as the count. Saturation and modulo behaviour therefore come out of plain repetition in the model, not out of a formula.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_SAR  = 4'd2,
    OP_SAL  = 4'd3,
    OP_ROTL = 4'd4,
    OP_ROTR = 4'd5,
    OP_RCL  = 4'd6,
    OP_RCR  = 4'd7,
    OP_CLRC = 4'd8,
    OP_SETC = 4'd9,
    OP_CPLC = 4'd10
  } shrot_op_e;

  typedef enum logic [1:0] {
    LIN_SHL = 2'd0,
    LIN_SHR = 2'd1,
    LIN_SAR = 2'd2,
    LIN_SAL = 2'd3
  } lin_mode_e;
endpackage

// File: rtl/shrot_linear.sv
module shrot_linear
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 5
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cin_i,
  input  lin_mode_e        mode_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o
);
  // One guard bit on the exit side catches the carry; shifts past the
  // width saturate naturally in the wide vectors.
  logic [WIDTH:0]          left_wide;
  logic [WIDTH:0]          right_wide;
  logic signed [WIDTH:0]   arith_wide;
  logic signed [WIDTH-1:0] shifted_back;

  always_comb begin
    left_wide    = {1'b0, opnd_i} << cnt_i;
    right_wide   = {opnd_i, 1'b0} >> cnt_i;
    arith_wide   = $signed({opnd_i, 1'b0}) >>> cnt_i;
    shifted_back = $signed(left_wide[WIDTH-1:0]) >>> cnt_i;
    ovf_o        = 1'b0;
    unique case (mode_i)
      LIN_SHL: begin
        res_o  = left_wide[WIDTH-1:0];
        cout_o = left_wide[WIDTH];
      end
      LIN_SHR: begin
        res_o  = right_wide[WIDTH:1];
        cout_o = right_wide[0];
      end
      LIN_SAR: begin
        res_o  = arith_wide[WIDTH:1];
        cout_o = arith_wide[0];
      end
      default: begin
        res_o  = left_wide[WIDTH-1:0];
        cout_o = left_wide[WIDTH];
        ovf_o  = (shifted_back != $signed(opnd_i));
      end
    endcase
    if (cnt_i == '0) begin
      cout_o = cin_i;
    end
  end

  always_comb begin
    if (cnt_i == '0) begin
      p_zero_count_r1: assert (res_o == opnd_i && cout_o == cin_i && !ovf_o)
        else $error("zero count altered operand or carry");
    end
    if (mode_i == LIN_SAR) begin
      p_sign_fill_r4: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1])
        else $error("arithmetic right lost the sign");
    end
    if (mode_i == LIN_SHR && cnt_i != '0) begin
      p_zero_fill_r3: assert (res_o[WIDTH-1] == 1'b0)
        else $error("logical right did not fill with zero");
    end
  end
endmodule

// File: rtl/shrot_rotate.sv
module shrot_rotate #(
  parameter int RING_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [RING_W-1:0] ring_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              right_i,
  output logic [RING_W-1:0] ring_o
);
  localparam int RW = $clog2(RING_W);

  logic [RW-1:0]     red_amt;
  logic [RW-1:0]     left_amt;
  logic [RING_W-1:0] stage [RW+1];

  // Reduce modulo the ring length, then express a right rotation as the
  // complementary left rotation.
  always_comb begin
    red_amt  = RW'(32'(cnt_i) % RING_W);
    left_amt = (right_i && red_amt != '0) ? RW'(RING_W - 32'(red_amt)) : red_amt;
  end

  assign stage[0] = ring_i;

  for (genvar gi = 0; gi < RW; gi++) begin : g_stage
    localparam int SH = 1 << gi;
    assign stage[gi+1] = left_amt[gi]
      ? {stage[gi][RING_W-1-SH:0], stage[gi][RING_W-1:RING_W-SH]}
      : stage[gi];
  end

  assign ring_o = stage[RW];

  always_comb begin
    p_ones_kept_r9: assert ($countones(ring_o) == $countones(ring_i))
      else $error("rotation changed the population of the ring");
  end
endmodule

// File: rtl/shrot_flag.sv
module shrot_flag
  import shrot_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_i,
  output logic            carry_o
);
  always_comb begin
    unique case (op_i)
      OP_CLRC: carry_o = 1'b0;
      OP_SETC: carry_o = 1'b1;
      OP_CPLC: carry_o = ~carry_i;
      default: carry_o = carry_i;
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 5
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             carry_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int XW = WIDTH + 1;

  lin_mode_e        lin_mode;
  logic [WIDTH-1:0] lin_res;
  logic             lin_cout;
  logic             lin_ovf;
  logic [WIDTH-1:0] rot_res;
  logic [XW-1:0]    rcx_res;
  logic             flag_c;
  logic             dir_right;

  assign lin_mode  = lin_mode_e'(op_i[1:0]);
  assign dir_right = op_i[0];

  shrot_linear #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_linear (
    .opnd_i (opnd_i),
    .cnt_i  (count_i),
    .cin_i  (carry_i),
    .mode_i (lin_mode),
    .res_o  (lin_res),
    .cout_o (lin_cout),
    .ovf_o  (lin_ovf)
  );

  shrot_rotate #(.RING_W(WIDTH), .CNT_W(CNT_W)) u_rot_plain (
    .ring_i  (opnd_i),
    .cnt_i   (count_i),
    .right_i (dir_right),
    .ring_o  (rot_res)
  );

  shrot_rotate #(.RING_W(XW), .CNT_W(CNT_W)) u_rot_carry (
    .ring_i  ({carry_i, opnd_i}),
    .cnt_i   (count_i),
    .right_i (dir_right),
    .ring_o  (rcx_res)
  );

  shrot_flag u_flag (
    .op_i    (op_i),
    .carry_i (carry_i),
    .carry_o (flag_c)
  );

  always_comb begin
    result_o = opnd_i;
    carry_o  = flag_c;
    ovf_o    = 1'b0;
    unique case (op_i)
      OP_SHL, OP_SHR, OP_SAR: begin
        result_o = lin_res;
        carry_o  = lin_cout;
      end
      OP_SAL: begin
        result_o = lin_res;
        carry_o  = lin_cout;
        ovf_o    = lin_ovf;
      end
      OP_ROTL, OP_ROTR: begin
        result_o = rot_res;
        if (count_i == '0) carry_o = carry_i;
        else               carry_o = dir_right ? rot_res[WIDTH-1] : rot_res[0];
      end
      OP_RCL, OP_RCR: begin
        result_o = rcx_res[WIDTH-1:0];
        carry_o  = rcx_res[WIDTH];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (ovf_o) begin
      p_ovf_only_sal_r11: assert (op_i == OP_SAL)
        else $error("overflow raised outside arithmetic left");
    end
    if (op_i[3]) begin
      p_flag_ops_keep_r10: assert (result_o == opnd_i)
        else $error("flag operation changed the operand");
    end
    if (!op_i[3] && count_i == '0) begin
      p_zero_count_r1: assert (result_o == opnd_i && carry_o == carry_i)
        else $error("zero count changed state");
    end
  end
endmodule

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;
  localparam int W  = 16;
  localparam int CW = 5;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  opnd;
  logic [CW-1:0] cnt;
  logic          cin;
  logic [3:0]    op;
  logic [W-1:0]  res;
  logic          cout;
  logic          ovf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int unsigned seed = 32'h1ace_b00c;

  shrot_unit #(.WIDTH(W), .CNT_W(CW)) dut (
    .opnd_i (opnd), .count_i (cnt), .carry_i (cin), .op_i (op),
    .result_o (res), .carry_o (cout), .ovf_o (ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Step-by-step reference: one bit movement per count unit.
  function automatic logic [W+1:0] model(input logic [3:0] o, input int k,
                                         input logic c, input logic [W-1:0] x);
    logic v = 1'b0;
    logic nc;
    logic [W-1:0] y;
    if (o <= 4'd7) begin
      for (int s = 0; s < k; s++) begin
        y = x;
        case (o)
          4'd0, 4'd3: begin c = y[W-1]; x = {y[W-2:0], 1'b0}; end
          4'd1: begin c = y[0]; x = {1'b0, y[W-1:1]}; end
          4'd2: begin c = y[0]; x = {y[W-1], y[W-1:1]}; end
          4'd4: begin c = y[W-1]; x = {y[W-2:0], y[W-1]}; end
          4'd5: begin c = y[0]; x = {y[0], y[W-1:1]}; end
          4'd6: begin nc = y[W-1]; x = {y[W-2:0], c}; c = nc; end
          default: begin nc = y[0]; x = {c, y[W-1:1]}; c = nc; end
        endcase
        if (o == 4'd3 && x[W-1] != y[W-1]) v = 1'b1;
      end
    end else if (o == 4'd8) c = 1'b0;
    else if (o == 4'd9) c = 1'b1;
    else if (o == 4'd10) c = ~c;
    return {v, c, x};
  endfunction

  task automatic run(input logic [3:0] o, input int k, input logic c,
                     input logic [W-1:0] x, input string tag);
    logic [W+1:0] exp;
    @(posedge clk);
    #1;
    op = o; cnt = CW'(k); cin = c; opnd = x;
    exp = model(o, k, c, x);
    @(negedge clk);
    total++;
    if ({ovf, cout, res} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d cnt=%0d: got ovf=%b c=%b res=%h expected ovf=%b c=%b res=%h",
               tag, o, k, ovf, cout, res, exp[W+1], exp[W], exp[W-1:0]);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o, input int k);
    if (k == 0 && o <= 4'd7) return "R1";
    if (o >= 4'd8) return "R10";
    if (k >= W && o <= 4'd3) return "R8";
    case (o)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5: return (k >= W) ? "R9" : "R6";
      default: return (k > W) ? "R9" : "R7";
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op = 4'd15; cnt = '0; cin = 1'b0; opnd = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state style check: idle code passes everything through (R10).
    run(4'd15, 0, 1'b1, 16'h1234, "R10");
    // R1: zero counts
    for (int o = 0; o < 8; o++) run(4'(o), 0, 1'b1, 16'hA5C3, "R1");
    // R2 / R3 / R4 / R5 directed
    run(4'd0, 2, 1'b0, 16'hC00F, "R2");
    run(4'd1, 2, 1'b0, 16'h000E, "R3");
    run(4'd2, 3, 1'b0, 16'h8004, "R4");
    run(4'd3, 1, 1'b0, 16'h4000, "R5");
    run(4'd3, 2, 1'b1, 16'hE001, "R5");
    run(4'd3, 3, 1'b0, 16'hD000, "R5");
    // R6 / R7 directed
    run(4'd4, 2, 1'b0, 16'h8001, "R6");
    run(4'd5, 1, 1'b0, 16'h0001, "R6");
    run(4'd6, 1, 1'b1, 16'h8000, "R7");
    run(4'd7, 2, 1'b1, 16'h0002, "R7");
    // R8: saturation at and past the width
    for (int o = 0; o < 4; o++) begin
      run(4'(o), W,     1'b1, 16'h8001, "R8");
      run(4'(o), W + 1, 1'b1, 16'h8001, "R8");
      run(4'(o), 31,    1'b0, 16'hFFFF, "R8");
    end
    // R9: modulo rotation counts
    run(4'd4, W,     1'b0, 16'h8003, "R9");
    run(4'd5, W + 3, 1'b1, 16'h1234, "R9");
    run(4'd6, W + 1, 1'b0, 16'hF0F0, "R9");
    run(4'd7, W + 1, 1'b1, 16'h0F0F, "R9");
    run(4'd6, W,     1'b1, 16'h0001, "R9");
    // R10: carry operations with nonzero count
    run(4'd8,  7, 1'b1, 16'hBEEF, "R10");
    run(4'd9,  3, 1'b0, 16'hBEEF, "R10");
    run(4'd10, 1, 1'b0, 16'h0000, "R10");
    run(4'd10, 9, 1'b1, 16'hFFFF, "R10");
    run(4'd12, 5, 1'b1, 16'h5555, "R10");
    // R11 and everything else: pseudo-random sweep
    for (int i = 0; i < 600; i++) begin
      logic [3:0] o;
      int k;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      o = seed[3:0];
      k = int'(seed[8:4]);
      run(o, k, seed[9], seed[31:16], (o != 4'd3) ? "R11" : tag_of(o, k));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule